// File: doc/BRIEF.md
# Programmable SPI Serial Clock Divider

This block derives the serial clock of an SPI engine from a faster source clock. A 32-bit configuration word holds three 6-bit fields: a divide value that sets the period, a high count that sets how long SCK stays high at the start of each period, and a low count. One further bit selects which tick source advances the divider. SCK can therefore be asymmetric or run at an odd ratio, rather than being limited to a plain divide-by-2N toggle.

While the engine holds `enable` high, SCK runs freely. Alongside it the block emits two single-cycle strobes that pace the shift logic: `sampleStb` marks the cycle in which SCK rises, and `launchStb` marks the cycle in which it falls. When `enable` is low, SCK rests low and the configuration word is tracked continuously. While running, a new word is adopted only when a period wraps, so no runt pulse can appear. With source select set, the divider advances only on cycles where the external `altTick` qualifier is high. All logic runs in the single `clk` domain.

Top module: `spi_sck_divider`

## Requirements
- R1: While `rst_n` is low, `sck`, `sampleStb` and `launchStb` are all 0.
- R2: A clock edge that samples `enable` low drives `sck` low after that edge, and neither strobe is asserted.
- R3: The SCK period is D+1 ticks, where D is bits 17:12 of the applied word. A value of 0 is treated as 1, so the fastest SCK is source/2 and the slowest (D=63) is source/64.
- R4: Each period starts with SCK high for H+1 ticks, where H is bits 11:6 of the applied word, and SCK is low for the rest of the period. An H that is not below the effective D is limited to D−1, so every period keeps at least one low tick.
- R5: `sampleStb` is 1 exactly in the cycles where `sck` has just gone 0→1 while enabled. `launchStb` is 1 exactly in the cycles where `sck` has just gone 1→0 while still enabled. The two strobes are never both 1.
- R6: While enabled, the applied word changes only at a period wrap, and the period that follows uses the new word in full. While disabled, the applied word follows `cfgWord`.
- R7: When bit 31 of the applied word is 1, the divider advances only on cycles where `altTick` is 1. When bit 31 is 0, it advances on every cycle.
- R8: Bits 5:0 (the low count) and bits 30:18 of the word have no effect on SCK or on the strobes.
- R9: On the first edge that samples `enable` high after idle, `sck` goes high and `sampleStb` fires in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High while the engine is in an active transfer |
| altTick | input | 1 | Advance qualifier used when the source-select bit is set |
| cfgWord | input | 32 | Clock configuration word |
| sck | output | 1 | Serial clock |
| sampleStb | output | 1 | Pulses in the cycle SCK rises |
| launchStb | output | 1 | Pulses in the cycle SCK falls |

## Verification
A corrupted phase counter or a badly applied configuration shows up at the ports within one SCK period. It appears as an SCK edge early or late, or as a strobe that no longer lines up with an SCK transition. The bench runs a cycle-accurate model derived from the requirements and compares all three outputs on every cycle. Any divergence is therefore reported in the cycle it first appears. Directed cases measure whole periods and high phases at the divide floor and ceiling, with a clamped high count, with ignored bits set, with a mid-period reprogram, and with the alternate tick source.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  localparam int FIELD_W = 6;
  localparam int CFG_W   = 32;
  localparam int DIV_LSB = 12;
  localparam int HI_LSB  = 6;
  localparam int SRC_BIT = 31;

  typedef struct packed {
    logic active;   // engine in a transfer
    logic advance;  // counter steps this cycle
    logic wrap;     // counter returns to zero this cycle
    logic load;     // applied word reloads this cycle
  } divCtrl_t;
endpackage

// File: rtl/sck_div_ctrl.sv
module sck_div_ctrl
  import sckdiv_pkg::*;
#(
  parameter bit HAS_ALT_SRC = 1'b1
) (
  input  logic     enable,
  input  logic     altTick,
  input  logic     srcSel,
  input  logic     atEnd,
  output divCtrl_t ctl
);
  logic tickOk;

  generate
    if (HAS_ALT_SRC) begin : g_alt
      assign tickOk = srcSel ? altTick : 1'b1;
    end else begin : g_fixed
      logic unusedSrc;
      assign unusedSrc = srcSel ^ altTick;
      assign tickOk = 1'b1;
    end
  endgenerate

  always_comb begin
    ctl.active  = enable;
    ctl.advance = enable && tickOk;
    ctl.wrap    = enable && tickOk && atEnd;
    ctl.load    = !enable || (tickOk && atEnd);
  end
endmodule

// File: rtl/sck_div_datapath.sv
module sck_div_datapath
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfgWord,
  input  divCtrl_t         ctl,
  output logic             srcSel,
  output logic             atEnd,
  output logic [CFG_W-1:0] appliedCfg,
  output logic             sck,
  output logic             sampleStb,
  output logic             launchStb
);
  logic [FIELD_W-1:0] count;
  logic [FIELD_W-1:0] divRaw, divEff, hiRaw, hiEff;
  logic               sckNext;
  logic               unusedCfg;

  assign divRaw = appliedCfg[DIV_LSB +: FIELD_W];
  assign hiRaw  = appliedCfg[HI_LSB +: FIELD_W];
  assign divEff = (divRaw == '0) ? FIELD_W'(1) : divRaw;
  assign hiEff  = (hiRaw >= divEff) ? (divEff - FIELD_W'(1)) : hiRaw;
  assign srcSel = appliedCfg[SRC_BIT];
  assign atEnd  = (count == divEff);
  assign unusedCfg = ^{appliedCfg[SRC_BIT-1:DIV_LSB+FIELD_W], appliedCfg[HI_LSB-1:0]};

  always_comb sckNext = ctl.active && (count <= hiEff);

  always_ff @(posedge clk) begin
    if (!rst_n) appliedCfg <= '0;
    else if (ctl.load) appliedCfg <= cfgWord;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ctl.active) count <= '0;
    else if (ctl.advance) count <= ctl.wrap ? '0 : count + FIELD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck       <= 1'b0;
      sampleStb <= 1'b0;
      launchStb <= 1'b0;
    end else begin
      sck       <= sckNext;
      sampleStb <= ctl.active && sckNext && !sck;
      launchStb <= ctl.active && !sckNext && sck;
    end
  end
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import sckdiv_pkg::*;
#(
  parameter bit HAS_ALT_SRC = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        altTick,
  input  logic [31:0] cfgWord,
  output logic        sck,
  output logic        sampleStb,
  output logic        launchStb
);
  divCtrl_t         ctl;
  logic             srcSel, atEnd, wrapFlag;
  logic [CFG_W-1:0] appliedCfg;

  assign wrapFlag = ctl.wrap;

  sck_div_ctrl #(.HAS_ALT_SRC(HAS_ALT_SRC)) u_ctrl (
    .enable (enable),
    .altTick(altTick),
    .srcSel (srcSel),
    .atEnd  (atEnd),
    .ctl    (ctl)
  );

  sck_div_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWord   (cfgWord),
    .ctl       (ctl),
    .srcSel    (srcSel),
    .atEnd     (atEnd),
    .appliedCfg(appliedCfg),
    .sck       (sck),
    .sampleStb (sampleStb),
    .launchStb (launchStb)
  );
endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        wrapFlag,
  input logic [31:0] appliedCfg,
  input logic        sck,
  input logic        sampleStb,
  input logic        launchStb
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sck && !sampleStb && !launchStb));

  p_rise_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |-> (sck && !$past(sck)));

  p_fall_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launchStb |-> (!sck && $past(sck)));

  p_rise_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> sampleStb);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampleStb && launchStb));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wrapFlag) |=> $stable(appliedCfg));
endmodule

bind spi_sck_divider spi_sck_divider_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .wrapFlag  (wrapFlag),
  .appliedCfg(appliedCfg),
  .sck       (sck),
  .sampleStb (sampleStb),
  .launchStb (launchStb)
);

// File: tb/spi_sck_divider_bench.sv
module spi_sck_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        altTick = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        sck, sampleStb, launchStb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  spi_sck_divider u_spi_sck_divider (
    .clk(clk), .rst_n(rst_n), .enable(enable), .altTick(altTick),
    .cfgWord(cfgWord), .sck(sck), .sampleStb(sampleStb), .launchStb(launchStb)
  );

  // reference model built from the requirements
  logic [31:0] mCfg;
  logic [5:0]  mCount;
  logic        mSck, mRise, mFall;

  function automatic logic [5:0] effDiv(input logic [31:0] c);
    return (c[17:12] == 6'd0) ? 6'd1 : c[17:12];
  endfunction

  function automatic logic [5:0] effHigh(input logic [31:0] c);
    logic [5:0] d = effDiv(c);
    return (c[11:6] >= d) ? d - 6'd1 : c[11:6];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCfg = '0; mCount = '0; mSck = 1'b0; mRise = 1'b0; mFall = 1'b0;
    end else begin
      logic nSck, tick;
      nSck  = enable && (mCount <= effHigh(mCfg));
      tick  = mCfg[31] ? altTick : 1'b1;
      mRise = enable && nSck && !mSck;
      mFall = enable && !nSck && mSck;
      mSck  = nSck;
      if (!enable) begin
        mCount = '0; mCfg = cfgWord;
      end else if (tick) begin
        if (mCount == effDiv(mCfg)) begin mCount = '0; mCfg = cfgWord; end
        else mCount = mCount + 6'd1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(enable ? "R4 sck" : "R2 sck", {31'd0, sck}, {31'd0, mSck});
      check("R5 strobes", {30'd0, sampleStb, launchStb}, {30'd0, mRise, mFall});
    end
  end

  bit altMode = 1'b0;

  task automatic measure(input logic [31:0] cfg, input bit alt, input int expP,
                         input int expH, input string tP, input string tH);
    int p = 0;
    int h = 1;
    int guard = 0;
    bit inHigh = 1'b1;
    @(negedge clk);
    enable = 1'b0; cfgWord = cfg; altMode = alt; altTick = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    do begin
      @(negedge clk); if (altMode) altTick = ~altTick;
      guard++;
    end while (!sampleStb && guard < 300);
    do begin
      @(negedge clk); if (altMode) altTick = ~altTick;
      p++;
      if (!sampleStb) begin
        if (sck && inHigh) h++; else inHigh = 1'b0;
      end
    end while (!sampleStb && p < 300);
    check(tP, p, expP);
    check(tH, h, expH);
    altMode = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit sel, input int d, input int hi);
    return {sel, 13'd0, 6'(d), 6'(hi), 6'(d)};
  endfunction

  initial begin : watchdog
    while (cycles < 150000 && !done) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 sck in reset", {31'd0, sck}, 32'd0);
    check("R1 strobes in reset", {30'd0, sampleStb, launchStb}, 32'd0);
    rst_n = 1'b1;

    // R9 start timing, then R2 idle
    cfgWord = mk(0, 3, 1);
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    check("R9 sck high on first enabled edge", {31'd0, sck}, 32'd1);
    check("R9 sample strobe on first enabled edge", {31'd0, sampleStb}, 32'd1);
    enable = 1'b0;
    @(negedge clk);
    check("R2 sck low after disable", {31'd0, sck}, 32'd0);
    check("R2 no launch strobe on disable", {31'd0, launchStb}, 32'd0);

    measure(mk(0, 3, 1),   0, 4,  2,  "R3 period div3",  "R4 high hi1");
    measure(mk(0, 0, 0),   0, 2,  1,  "R3 period floor", "R4 high floor");
    measure(mk(0, 63, 31), 0, 64, 32, "R3 period max",   "R4 high max");
    measure(mk(0, 5, 9),   0, 6,  5,  "R3 period div5",  "R4 high clamped");
    measure(mk(0, 4, 1) | 32'h7FFC_002A, 0, 5, 2, "R8 period ignored bits", "R8 high ignored bits");
    measure(mk(1, 3, 1),   1, 8,  4,  "R7 period alt src", "R7 high alt src");

    // R6: reprogram right after a rise; the running period keeps its length
    begin
      int p = 0;
      @(negedge clk); enable = 1'b0; cfgWord = mk(0, 7, 3);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      cfgWord = mk(0, 1, 0);
      do begin @(negedge clk); p++; end while (!sampleStb && p < 100);
      check("R6 old period completes", p, 8);
      p = 0;
      do begin @(negedge clk); p++; end while (!sampleStb && p < 100);
      check("R6 new period applied", p, 2);
    end

    // constrained random traffic, compared every cycle by the model
    begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if ($urandom_range(39) == 0)
          cfgWord = {1'($urandom_range(1)), 13'($urandom), 6'($urandom), 6'($urandom), 6'($urandom)};
        if ($urandom_range(59) == 0) enable = ~enable;
        altTick = 1'($urandom_range(1));
      end
    end

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule